// File: doc/BRIEF.md
# DTMF Digital Tone Synthesizer

This block turns a 4-bit telephone keypad code into a stream of signed digital samples that carry the matching dual-tone pair. Each of the two tone groups has its own divider running from a 3.579545 MHz sample tick. The divider counts a segment length chosen by the digit, and at the end of each segment it advances a 5-bit phase through a 32-point sine period. The two sine lookups are scaled, with the high group about 2 dB louder than the low group, and then summed into one output word.

The sample tick is a clock-enable input, so the block runs on any faster system clock. Software or a sequencer drives the digit, the tone enable and the single/dual and column/row selects directly. The output feeds a D/A converter and smoothing filter outside this block. One registered sample is produced per tick, together with a one-cycle valid strobe.

Top module: `dtmf_synth`

## Requirements
- R1: While and after synchronous reset `rst`, `sample` is 0 and `sample_valid` is 0 until the first tick.
- R2: Digit codes map to a row (low group) and a column (high group). Code 0001..1001 are keys 1..9, 1010 is 0, 1011 is *, 1100 is #, 1101..1111 are A..C and 0000 is D. Rows are {1,2,3,A}, {4,5,6,B}, {7,8,9,C} and {*,0,#,D}. Columns are {1,4,7,*}, {2,5,8,0}, {3,6,9,#} and {A,B,C,D}. In dual mode (`single_sel`=0), `sample` is the sum of the two scaled tones.
- R3: Each group advances its phase once every N ticks. Row N is 160, 146, 132 or 118, which gives 699.1, 766.2, 847.4 or 948.0 Hz. Column N is 92, 84, 76 or 68, which gives 1215.9, 1331.7, 1471.9 or 1645.0 Hz.
- R4: A tone period is 32 phase steps, and the phase wraps modulo 32. The value at phase k is round(127·sin(2πk/32)) times the group gain. On a tick the output takes the value for the phase held before that tick, and between ticks it holds.
- R5: The low group is scaled by LOW_GAIN (4) and the high group by HIGH_GAIN (5), so single-tone peaks are 508 and 635. No sample ever exceeds ±(LOW_GAIN+HIGH_GAIN)·127.
- R6: In single mode (`single_sel`=1), only one group is output: the high group when `col_sel`=1 and the low group when `col_sel`=0.
- R7: While `tone_en`=0, every tick outputs 0 and both dividers and phases are held at zero. The first sample after enable is therefore phase 0.
- R8: `sample_valid` is high in exactly the cycle after each cycle in which `tick` was high.
- R9: Each group takes its segment length from the digit currently applied. If the count already reached is at or beyond the new length minus one, the divider wraps on the next tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Sample-rate enable (3.579545 MHz rate) |
| digit | input | 4 | Keypad code |
| tone_en | input | 1 | Tone enable; low silences and rewinds |
| single_sel | input | 1 | 1 = single tone, 0 = dual tone |
| col_sel | input | 1 | In single mode: 1 = high group, 0 = low group |
| sample | output | OUT_W (12) | Signed output sample |
| sample_valid | output | 1 | One-cycle strobe after each tick |

## Verification
Each of the eight tones is tried alone with a tick every cycle. Counting the zero samples before the first step, and then finding the peak over one period, separates the divisor of every row and column and the gain of each group. Random segments then mix digits, dual and single modes, both group selects, sparse and dense tick patterns, enable drops and digit changes without a disable. These are compared against a bench model built from real-valued frequencies and a sine. Enable drops show that a burst restarts at phase 0, and mid-tone digit changes show the wrap rule when the count overshoots a shorter divisor.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;
  localparam int SEG_COUNT = 32;
  localparam int PHASE_W   = $clog2(SEG_COUNT);
  localparam int DIV_W     = 8;
  localparam int SINE_W    = 8;
  localparam int SINE_PEAK = 127;

  // row (low group) index of a keypad code
  function automatic logic [1:0] row_of(input logic [3:0] c);
    case (c)
      4'd1, 4'd2, 4'd3, 4'd13: row_of = 2'd0;
      4'd4, 4'd5, 4'd6, 4'd14: row_of = 2'd1;
      4'd7, 4'd8, 4'd9, 4'd15: row_of = 2'd2;
      default:                 row_of = 2'd3;
    endcase
  endfunction

  // column (high group) index of a keypad code
  function automatic logic [1:0] col_of(input logic [3:0] c);
    case (c)
      4'd1, 4'd4, 4'd7, 4'd11: col_of = 2'd0;
      4'd2, 4'd5, 4'd8, 4'd10: col_of = 2'd1;
      4'd3, 4'd6, 4'd9, 4'd12: col_of = 2'd2;
      default:                 col_of = 2'd3;
    endcase
  endfunction

  function automatic logic [DIV_W-1:0] row_div(input logic [1:0] r);
    case (r)
      2'd0:    row_div = DIV_W'(160);
      2'd1:    row_div = DIV_W'(146);
      2'd2:    row_div = DIV_W'(132);
      default: row_div = DIV_W'(118);
    endcase
  endfunction

  function automatic logic [DIV_W-1:0] col_div(input logic [1:0] k);
    case (k)
      2'd0:    col_div = DIV_W'(92);
      2'd1:    col_div = DIV_W'(84);
      2'd2:    col_div = DIV_W'(76);
      default: col_div = DIV_W'(68);
    endcase
  endfunction

  // quarter-wave magnitudes, index 0..8
  function automatic logic [SINE_W-1:0] quarter(input logic [3:0] i);
    case (i)
      4'd0:    quarter = SINE_W'(0);
      4'd1:    quarter = SINE_W'(25);
      4'd2:    quarter = SINE_W'(49);
      4'd3:    quarter = SINE_W'(71);
      4'd4:    quarter = SINE_W'(90);
      4'd5:    quarter = SINE_W'(106);
      4'd6:    quarter = SINE_W'(117);
      4'd7:    quarter = SINE_W'(125);
      default: quarter = SINE_W'(SINE_PEAK);
    endcase
  endfunction

  function automatic logic signed [SINE_W-1:0] sine_at(input logic [PHASE_W-1:0] ph);
    logic [3:0]        idx;
    logic [SINE_W-1:0] mag;
    idx = ph[3] ? (4'd8 - {1'b0, ph[2:0]}) : {1'b0, ph[2:0]};
    mag = quarter(idx);
    sine_at = ph[4] ? -$signed(mag) : $signed(mag);
  endfunction
endpackage

// File: rtl/dtmf_code_map.sv
module dtmf_code_map
  import dtmf_pkg::*;
(
  input  logic [3:0]       digit,
  output logic [DIV_W-1:0] div_lo,
  output logic [DIV_W-1:0] div_hi
);
  always_comb begin
    div_lo = row_div(row_of(digit));
    div_hi = col_div(col_of(digit));
  end
endmodule

// File: rtl/dtmf_tone_div.sv
module dtmf_tone_div #(
  parameter int DIV_W   = 8,
  parameter int PHASE_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               run,
  input  logic [DIV_W-1:0]   divisor,
  output logic [PHASE_W-1:0] phase
);
  logic [DIV_W-1:0] seg_cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      seg_cnt <= '0;
      phase   <= '0;
    end else if (tick) begin
      if (seg_cnt >= divisor - 1'b1) begin
        seg_cnt <= '0;
        phase   <= phase + 1'b1;
      end else begin
        seg_cnt <= seg_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dtmf_mixer.sv
module dtmf_mixer
  import dtmf_pkg::*;
#(
  parameter int LOW_GAIN  = 4,
  parameter int HIGH_GAIN = 5,
  parameter int OUT_W     = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tick,
  input  logic                    tone_en,
  input  logic                    single_sel,
  input  logic                    col_sel,
  input  logic [PHASE_W-1:0]      phase_lo,
  input  logic [PHASE_W-1:0]      phase_hi,
  output logic signed [OUT_W-1:0] sample,
  output logic                    sample_valid
);
  logic signed [OUT_W-1:0] lo_raw, hi_raw, lo_w, hi_w, mix_w;

  always_comb begin
    lo_raw = OUT_W'(sine_at(phase_lo));
    hi_raw = OUT_W'(sine_at(phase_hi));
    lo_w   = lo_raw * $signed(OUT_W'(LOW_GAIN));
    hi_w   = hi_raw * $signed(OUT_W'(HIGH_GAIN));
    if (single_sel) mix_w = col_sel ? hi_w : lo_w;
    else            mix_w = lo_w + hi_w;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sample       <= '0;
      sample_valid <= 1'b0;
    end else begin
      sample_valid <= tick;
      if (tick) sample <= tone_en ? mix_w : '0;
    end
  end
endmodule

// File: rtl/dtmf_synth.sv
module dtmf_synth
  import dtmf_pkg::*;
#(
  parameter int LOW_GAIN  = 4,
  parameter int HIGH_GAIN = 5,
  parameter int OUT_W     = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tick,
  input  logic [3:0]              digit,
  input  logic                    tone_en,
  input  logic                    single_sel,
  input  logic                    col_sel,
  output logic signed [OUT_W-1:0] sample,
  output logic                    sample_valid
);
  localparam int GROUPS = 2;

  logic [DIV_W-1:0]   div_g [GROUPS];
  logic [PHASE_W-1:0] ph_g  [GROUPS];

  dtmf_code_map map_i (
    .digit  (digit),
    .div_lo (div_g[0]),
    .div_hi (div_g[1])
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    dtmf_tone_div #(.DIV_W(DIV_W), .PHASE_W(PHASE_W)) div_i (
      .clk     (clk),
      .rst     (rst),
      .tick    (tick),
      .run     (tone_en),
      .divisor (div_g[g]),
      .phase   (ph_g[g])
    );
  end

  dtmf_mixer #(.LOW_GAIN(LOW_GAIN), .HIGH_GAIN(HIGH_GAIN), .OUT_W(OUT_W)) mix_i (
    .clk          (clk),
    .rst          (rst),
    .tick         (tick),
    .tone_en      (tone_en),
    .single_sel   (single_sel),
    .col_sel      (col_sel),
    .phase_lo     (ph_g[0]),
    .phase_hi     (ph_g[1]),
    .sample       (sample),
    .sample_valid (sample_valid)
  );
endmodule

// File: rtl/dtmf_synth_chk.sv
module dtmf_synth_chk #(
  parameter int LOW_GAIN  = 4,
  parameter int HIGH_GAIN = 5,
  parameter int OUT_W     = 12
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    tick,
  input logic                    tone_en,
  input logic signed [OUT_W-1:0] sample,
  input logic                    sample_valid
);
  localparam int MAXV = (LOW_GAIN + HIGH_GAIN) * 127;

  p_valid_after_tick_r8: assert property (@(posedge clk) disable iff (rst)
    tick |=> sample_valid);

  p_no_valid_without_tick_r8: assert property (@(posedge clk) disable iff (rst)
    !tick |=> !sample_valid);

  p_hold_between_ticks_r4: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(sample));

  p_silent_when_off_r7: assert property (@(posedge clk) disable iff (rst)
    (!tone_en && tick) |=> (sample == '0));

  p_burst_starts_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(tone_en) && tone_en && tick) |=> (sample == '0));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    sample_valid |-> ((int'(sample) <= MAXV) && (int'(sample) >= -MAXV)));
endmodule

bind dtmf_synth dtmf_synth_chk #(
  .LOW_GAIN(LOW_GAIN), .HIGH_GAIN(HIGH_GAIN), .OUT_W(OUT_W)
) chk_i (
  .clk(clk), .rst(rst), .tick(tick), .tone_en(tone_en),
  .sample(sample), .sample_valid(sample_valid)
);

// File: tb/dtmf_synth_tb_top.sv
module dtmf_synth_tb_top;
  localparam int LG = 4;
  localparam int HG = 5;
  localparam int OW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic [3:0] digit = 4'd1;
  logic tone_en = 1'b0;
  logic single_sel = 1'b0;
  logic col_sel = 1'b0;
  logic signed [OW-1:0] sample;
  logic sample_valid;

  int n_chk = 0;
  int n_fail = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  dtmf_synth #(.LOW_GAIN(LG), .HIGH_GAIN(HG), .OUT_W(OW)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .digit(digit), .tone_en(tone_en),
    .single_sel(single_sel), .col_sel(col_sel),
    .sample(sample), .sample_valid(sample_valid)
  );

  // ---------------- reference functions ----------------
  function automatic int b_row(input int c);
    if (c >= 1 && c <= 9) return (c - 1) / 3;
    if (c >= 13) return c - 13;
    return 3;
  endfunction

  function automatic int b_col(input int c);
    if (c >= 1 && c <= 9) return (c - 1) % 3;
    if (c == 11) return 0;
    if (c == 10) return 1;
    if (c == 12) return 2;
    return 3;
  endfunction

  function automatic int b_div(input int grp, input int idx);
    real f;
    real lo [4] = '{699.1, 766.2, 847.4, 948.0};
    real hi [4] = '{1215.9, 1331.7, 1471.9, 1645.0};
    f = (grp == 0) ? lo[idx] : hi[idx];
    return $rtoi($floor(3579545.0 / (32.0 * f) + 0.5));
  endfunction

  function automatic int b_sine(input int k);
    real v;
    v = 127.0 * $sin(2.0 * 3.14159265358979 * k / 32.0);
    return $rtoi($floor(v + 0.5));
  endfunction

  function automatic int b_mix(input int pl, input int ph, input bit sgl, input bit col);
    int lo, hi;
    lo = LG * b_sine(pl);
    hi = HG * b_sine(ph);
    if (sgl) return col ? hi : lo;
    return lo + hi;
  endfunction

  // ---------------- lockstep model ----------------
  int m_cnt [2];
  int m_ph  [2];
  int e_smp = 0;
  bit e_val = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = '{0, 0}; m_ph = '{0, 0}; e_smp = 0; e_val = 1'b0;
    end else begin
      e_val = tick;
      if (tick) e_smp = tone_en ? b_mix(m_ph[0], m_ph[1], single_sel, col_sel) : 0;
      for (int g = 0; g < 2; g++) begin
        int d;
        d = (g == 0) ? b_div(0, b_row(digit)) : b_div(1, b_col(digit));
        if (!tone_en) begin
          m_cnt[g] = 0; m_ph[g] = 0;
        end else if (tick) begin
          if (m_cnt[g] >= d - 1) begin
            m_cnt[g] = 0; m_ph[g] = (m_ph[g] + 1) % 32;
          end else m_cnt[g] = m_cnt[g] + 1;
        end
      end
    end
  end

  task automatic check(input bit ok, input string t, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", t, act, exp, $time);
    end
  endtask

  // continuous comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      check(int'(sample) == e_smp, tag, int'(sample), e_smp);
      check(sample_valid == e_val, "R8", int'(sample_valid), int'(e_val));
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    int zeros, first_nz, peak, d, grp, idx;
    int codes_lo [4] = '{1, 4, 7, 11};
    int codes_hi [4] = '{1, 2, 3, 13};
    void'($urandom(32'd4242));

    repeat (3) @(negedge clk);
    check(int'(sample) == 0, "R1", int'(sample), 0);
    check(sample_valid == 1'b0, "R1", int'(sample_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check(int'(sample) == 0, "R1", int'(sample), 0);
    check(sample_valid == 1'b0, "R1", int'(sample_valid), 0);

    // directed: each tone alone, tick every cycle
    for (int t = 0; t < 8; t++) begin
      grp = t / 4; idx = t % 4;
      tag = "R6";
      tone_en = 1'b0; tick = 1'b1; single_sel = 1'b1; col_sel = grp[0];
      digit = (grp == 0) ? codes_lo[idx][3:0] : codes_hi[idx][3:0];
      d = b_div(grp, idx);
      repeat (3) @(negedge clk);
      tone_en = 1'b1;
      zeros = 0; first_nz = 0;
      for (int c = 0; c < 400; c++) begin
        @(negedge clk);
        if (sample != 0) begin first_nz = int'(sample); break; end
        zeros++;
      end
      check(zeros == d, "R3", zeros, d);
      check(first_nz == ((grp == 0) ? LG : HG) * 25, "R4", first_nz,
            ((grp == 0) ? LG : HG) * 25);
      peak = 0;
      for (int c = 0; c < 32 * d; c++) begin
        @(negedge clk);
        if (int'(sample) > peak) peak = int'(sample);
      end
      check(peak == ((grp == 0) ? LG : HG) * 127, "R5", peak,
            ((grp == 0) ? LG : HG) * 127);
    end

    // directed: disable silences output (R7)
    tag = "R7";
    tone_en = 1'b0;
    repeat (2) @(negedge clk);
    check(int'(sample) == 0, "R7", int'(sample), 0);

    // random segments
    for (int s = 0; s < 200; s++) begin
      int len, den, kind;
      len  = 40 + int'($urandom % 460);
      den  = 1 + int'($urandom % 4);
      kind = int'($urandom % 10);
      single_sel = ($urandom % 3) == 0;
      col_sel    = $urandom % 2;
      if (kind < 2) begin
        tone_en = 1'b0; tag = "R7";
      end else begin
        tone_en = 1'b1;
        tag = (kind < 5) ? "R9" : (single_sel ? "R6" : "R2");
      end
      digit = 4'($urandom % 16);
      for (int c = 0; c < len; c++) begin
        tick = ($urandom % den) == 0;
        @(negedge clk);
      end
    end

    tick = 1'b0;
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule